// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs one coprocessor instruction against an external coprocessor port. After a start strobe it offers the instruction to the coprocessor. It then follows the two-bit reply the coprocessor returns on each step. The instruction can be an internal coprocessor operation, a register write to the coprocessor, a register read from it, or a block load or store between memory and the coprocessor. During a block transfer the sequencer drives the memory address and the read or write strobe. It routes each word between the memory port and the coprocessor port.

While the coprocessor answers busy, the sequencer spends one retry cycle per busy reply. A pending interrupt during that wait makes it drop the instruction and tell the coprocessor so. Too many consecutive busy replies end the instruction with a timeout. Each instruction ends with a one-cycle `done` pulse and a status code that reports success, an undefined-instruction trap, a data abort, an interruption or a timeout.

Top module: `cop_handshake_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `cp_phase` is NONE (0), `done` is 0, and `mem_rd` and `mem_wr` are 0.
- R2: An accepted `start` (seen only when no instruction is running) shows phase FIRST (1) in the next cycle. Each busy reply (01) on FIRST or BUSY shows phase BUSY (2) in the following cycle and makes no memory access. An internal operation (op 0) completes `nb+2` cycles after the strobe, where `nb` is the number of busy replies.
- R3: A busy reply while `int_pend` is high shows phase INTR (3) for one cycle, then `done` with status INTR (3), with no memory access. `int_pend` has no effect when the reply is not busy.
- R4: A cannot reply (10) gives `done` with status UNDEF (1) in the next cycle, with no memory access. For a register read (op 2) `rd_data` becomes `flags_in` in bits 31:28 with all other bits 0. Op codes 5 to 7 give UNDEF in the cycle after the strobe.
- R5: An accept (00) or increment (11) reply to an internal operation gives `done` with status OK (0) in the next cycle.
- R6: A register write (op 1) shows one DATA (4) cycle that carries `src_data` on `cp_wdata`, then `done` with status OK.
- R7: A register read (op 2) shows one DATA cycle, stores `cp_rdata` into `rd_data`, then `done` with status OK.
- R8: A block load (op 3) or store (op 4) moves its first word at `start_addr` unchanged. Each increment reply in a DATA cycle moves one more word at an address 4 higher, and any other reply ends the burst after the current word. A load routes `mem_rdata` to `cp_wdata`, and a store routes `cp_rdata` to `mem_wdata`.
- R9: A load or store whose address has any bit above bit 25 set, or a store below byte address 32, gives `done` with status ABORT (2) in the next cycle without any phase toward the coprocessor.
- R10: A `mem_abort` seen in any DATA cycle of a burst does not shorten the burst. It makes the final status ABORT.
- R11: After 256 consecutive busy replies the instruction ends with `done` and status TIMEOUT (4), with 255 BUSY cycles shown.
- R12: A `start` strobe while an instruction is running is ignored and does not change its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for one instruction |
| op | input | 3 | Operation: 0 internal, 1 reg write, 2 reg read, 3 load, 4 store |
| start_addr | input | 32 | Byte address of the first block word |
| src_data | input | 32 | Word sent to the coprocessor on a register write |
| flags_in | input | 4 | Current condition flags, returned on a failed register read |
| int_pend | input | 1 | Interrupt pending |
| mem_abort | input | 1 | Memory abort for the current block word |
| cp_phase | output | 3 | Step shown to coprocessor: 0 none, 1 first, 2 busy, 3 intr, 4 data |
| cp_resp | input | 2 | Coprocessor reply: 00 accept, 01 busy, 10 cannot, 11 increment |
| cp_wdata | output | 32 | Word toward the coprocessor |
| cp_rdata | input | 32 | Word from the coprocessor |
| mem_addr | output | 32 | Block transfer address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Memory read data, valid in the cycle of `mem_rd` |
| mem_wdata | output | 32 | Memory write data |
| done | output | 1 | One-cycle end-of-instruction pulse |
| status | output | 3 | Result: 0 OK, 1 UNDEF, 2 ABORT, 3 INTR, 4 TIMEOUT |
| rd_data | output | 32 | Result of a register read |

## Verification
The properties assume that the coprocessor answers within the same cycle as the phase it is shown. They also assume that `cp_resp`, `mem_rdata` and `mem_abort` are read only while a phase is active, and that all inputs are synchronous to `clk`. The bench models the coprocessor as combinational logic driven by the phase output and by scripted reply counts, and its memory as a pure function of the address. Inputs change only on falling edges, so every reply the sequencer samples is settled and belongs to the phase being shown.

// File: rtl/cpseq_pkg.sv
package cpseq_pkg;

  typedef enum logic [2:0] {
    PH_NONE  = 3'd0,
    PH_FIRST = 3'd1,
    PH_BUSY  = 3'd2,
    PH_INTR  = 3'd3,
    PH_DATA  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    RSP_ACCEPT = 2'b00,
    RSP_BUSY   = 2'b01,
    RSP_CANT   = 2'b10,
    RSP_INC    = 2'b11
  } resp_e;

  typedef enum logic [2:0] {
    OP_INTERNAL = 3'd0,
    OP_PUT      = 3'd1,
    OP_GET      = 3'd2,
    OP_LOAD     = 3'd3,
    OP_STORE    = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_UNDEF   = 3'd1,
    ST_ABORT   = 3'd2,
    ST_INTR    = 3'd3,
    ST_TIMEOUT = 3'd4
  } stat_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ASK,
    S_XFER,
    S_BURST,
    S_INTR
  } state_e;

endpackage

// File: rtl/cpseq_addr_guard.sv
module cpseq_addr_guard #(
  parameter int AW         = 32,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          is_store,
  output logic          bad
);
  logic out_of_range;
  logic in_vectors;

  assign out_of_range = |(addr >> LEGAL_BITS);
  assign in_vectors   = (addr < AW'(VEC_BYTES));
  assign bad          = out_of_range || (is_store && in_vectors);
endmodule

// File: rtl/cpseq_busy_ctr.sv
module cpseq_busy_ctr #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/cpseq_addr_gen.sv
module cpseq_addr_gen #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (adv)  addr <= addr + AW'(STEP);
  end
endmodule

// File: rtl/cop_handshake_seq.sv
module cop_handshake_seq
  import cpseq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FLAG_W     = 4,
  parameter int LEGAL_BITS = 26,
  parameter int VEC_BYTES  = 32,
  parameter int BUSY_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] src_data,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic          int_pend,
  input  logic          mem_abort,
  output logic [2:0]    cp_phase,
  input  logic [1:0]    cp_resp,
  output logic [DW-1:0] cp_wdata,
  input  logic [DW-1:0] cp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic [2:0]    status,
  output logic [DW-1:0] rd_data
);
  localparam int WORD_BYTES = DW / 8;
  localparam int PAD_W      = DW - FLAG_W;

  state_e state;
  op_e    op_q;
  logic   first_q;
  logic   abort_seen;
  logic   addr_bad;
  logic   at_limit;
  logic   is_mem_op;
  resp_e  rsp;

  assign rsp       = resp_e'(cp_resp);
  assign is_mem_op = (op == 3'(OP_LOAD)) || (op == 3'(OP_STORE));

  cpseq_addr_guard #(.AW(AW), .LEGAL_BITS(LEGAL_BITS), .VEC_BYTES(VEC_BYTES)) u_guard (
    .addr     (start_addr),
    .is_store (op == 3'(OP_STORE)),
    .bad      (addr_bad)
  );

  cpseq_busy_ctr #(.LIMIT(BUSY_LIMIT)) u_busy (
    .clk      (clk),
    .rst      (rst),
    .clr      (state != S_ASK),
    .bump     (state == S_ASK && rsp == RSP_BUSY),
    .at_limit (at_limit)
  );

  cpseq_addr_gen #(.AW(AW), .STEP(WORD_BYTES)) u_agen (
    .clk      (clk),
    .rst      (rst),
    .load     (state == S_IDLE && start),
    .load_val (start_addr),
    .adv      (state == S_BURST && rsp == RSP_INC),
    .addr     (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_INTERNAL;
      first_q    <= 1'b0;
      abort_seen <= 1'b0;
      done       <= 1'b0;
      status     <= 3'(ST_OK);
      rd_data    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          op_q       <= op_e'(op);
          abort_seen <= 1'b0;
          if (op > 3'(OP_STORE)) begin
            done <= 1'b1; status <= 3'(ST_UNDEF);
          end else if (is_mem_op && addr_bad) begin
            done <= 1'b1; status <= 3'(ST_ABORT);
          end else begin
            state   <= S_ASK;
            first_q <= 1'b1;
          end
        end
        S_ASK: begin
          first_q <= 1'b0;
          unique case (rsp)
            RSP_BUSY: begin
              if (int_pend) state <= S_INTR;
              else if (at_limit) begin
                state <= S_IDLE; done <= 1'b1; status <= 3'(ST_TIMEOUT);
              end
            end
            RSP_CANT: begin
              state <= S_IDLE; done <= 1'b1; status <= 3'(ST_UNDEF);
              if (op_q == OP_GET) rd_data <= {flags_in, {PAD_W{1'b0}}};
            end
            default: begin
              unique case (op_q)
                OP_PUT, OP_GET:    state <= S_XFER;
                OP_LOAD, OP_STORE: state <= S_BURST;
                default: begin
                  state <= S_IDLE; done <= 1'b1; status <= 3'(ST_OK);
                end
              endcase
            end
          endcase
        end
        S_XFER: begin
          if (op_q == OP_GET) rd_data <= cp_rdata;
          state <= S_IDLE; done <= 1'b1; status <= 3'(ST_OK);
        end
        S_BURST: begin
          if (mem_abort) abort_seen <= 1'b1;
          if (rsp != RSP_INC) begin
            state  <= S_IDLE;
            done   <= 1'b1;
            status <= (abort_seen || mem_abort) ? 3'(ST_ABORT) : 3'(ST_OK);
          end
        end
        S_INTR: begin
          state <= S_IDLE; done <= 1'b1; status <= 3'(ST_INTR);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      S_ASK:          cp_phase = first_q ? 3'(PH_FIRST) : 3'(PH_BUSY);
      S_XFER, S_BURST: cp_phase = 3'(PH_DATA);
      S_INTR:         cp_phase = 3'(PH_INTR);
      default:        cp_phase = 3'(PH_NONE);
    endcase
  end

  assign mem_rd    = (state == S_BURST) && (op_q == OP_LOAD);
  assign mem_wr    = (state == S_BURST) && (op_q == OP_STORE);
  assign mem_wdata = mem_wr ? cp_rdata : '0;

  always_comb begin
    if (state == S_XFER && op_q == OP_PUT) cp_wdata = src_data;
    else if (mem_rd)                        cp_wdata = mem_rdata;
    else                                    cp_wdata = '0;
  end
endmodule

// File: rtl/cop_handshake_seq_chk.sv
module cop_handshake_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    cp_phase,
  input logic [1:0]    cp_resp,
  input logic          int_pend,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          done,
  input logic [2:0]    status
);
  logic asking;
  assign asking = (cp_phase == 3'd1) || (cp_phase == 3'd2);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (cp_phase == 3'd0 && !done && !mem_rd && !mem_wr));

  a_r2_first_busy_retry: assert property (@(posedge clk) disable iff (rst)
    (cp_phase == 3'd1 && cp_resp == 2'b01 && !int_pend) |=> (cp_phase == 3'd2));

  a_r2_mem_only_in_data: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (cp_phase == 3'd4 && $onehot0({mem_rd, mem_wr})));

  a_r3_busy_irq_gives_up: assert property (@(posedge clk) disable iff (rst)
    (asking && cp_resp == 2'b01 && int_pend) |=> (cp_phase == 3'd3));

  a_r3_intr_then_done: assert property (@(posedge clk) disable iff (rst)
    (cp_phase == 3'd3) |=> (done && status == 3'd3 && cp_phase == 3'd0));

  a_r4_cannot_traps: assert property (@(posedge clk) disable iff (rst)
    (asking && cp_resp == 2'b10) |=> (done && status == 3'd1));

  a_r8_inc_steps_addr: assert property (@(posedge clk) disable iff (rst)
    ((mem_rd || mem_wr) && cp_resp == 2'b11) |=>
      ((mem_rd || mem_wr) && mem_addr == $past(mem_addr) + AW'(4)));
endmodule

bind cop_handshake_seq cop_handshake_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cp_phase (cp_phase),
  .cp_resp  (cp_resp),
  .int_pend (int_pend),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .done     (done),
  .status   (status)
);

// File: tb/cop_handshake_seq_tb.sv
module cop_handshake_seq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [2:0]  op;
  logic [31:0] start_addr, src_data;
  logic [3:0]  flags_in;
  logic        int_pend, mem_abort;
  logic [2:0]  cp_phase;
  logic [1:0]  cp_resp;
  logic [31:0] cp_wdata, cp_rdata, mem_addr, mem_rdata, mem_wdata, rd_data;
  logic        mem_rd, mem_wr, done;
  logic [2:0]  status;

  always #10 clk = ~clk;

  cop_handshake_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .start_addr(start_addr),
    .src_data(src_data), .flags_in(flags_in), .int_pend(int_pend),
    .mem_abort(mem_abort), .cp_phase(cp_phase), .cp_resp(cp_resp),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .done(done), .status(status), .rd_data(rd_data)
  );

  int n_vec = 0;
  int n_bad = 0;

  // coprocessor script
  int        s_busy, s_inc, s_abort_at;
  logic [1:0] s_final;
  int        ask_cnt, data_cnt;
  // observation
  int        n_busy_ph, n_intr_ph, n_data_ph, n_any_ph, n_mem;
  logic [31:0] log_addr [16];
  logic [31:0] log_data [16];

  always_comb begin
    cp_resp = 2'b00;
    if (cp_phase == 3'd1 || cp_phase == 3'd2)
      cp_resp = (ask_cnt < s_busy) ? 2'b01 : s_final;
    else if (cp_phase == 3'd4)
      cp_resp = (data_cnt < s_inc) ? 2'b11 : 2'b00;
  end
  assign cp_rdata  = 32'hC0DE_0000 + 32'(data_cnt);
  assign mem_rdata = mem_addr ^ 32'hA5A5_0000;
  assign mem_abort = (cp_phase == 3'd4) && (data_cnt == s_abort_at);

  always @(posedge clk) begin
    if (cp_phase == 3'd1 || cp_phase == 3'd2) ask_cnt <= ask_cnt + 1;
    if (cp_phase != 3'd0) n_any_ph <= n_any_ph + 1;
    if (cp_phase == 3'd2) n_busy_ph <= n_busy_ph + 1;
    if (cp_phase == 3'd3) n_intr_ph <= n_intr_ph + 1;
    if (cp_phase == 3'd4) begin
      data_cnt  <= data_cnt + 1;
      n_data_ph <= n_data_ph + 1;
      if (data_cnt < 16) begin
        log_addr[data_cnt] <= mem_addr;
        log_data[data_cnt] <= mem_wr ? mem_wdata : cp_wdata;
      end
    end
    if (mem_rd || mem_wr) n_mem <= n_mem + 1;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // run one instruction; returns status and cycles from strobe to done
  task automatic run(input logic [2:0] o, input logic [31:0] a, input int nb,
                     input logic [1:0] fin, input int ninc, input int abt,
                     input logic irq, input logic poke, output logic [2:0] st, output int cyc);
    @(negedge clk);
    s_busy = nb; s_final = fin; s_inc = ninc; s_abort_at = abt;
    ask_cnt = 0; data_cnt = 0; n_busy_ph = 0; n_intr_ph = 0; n_data_ph = 0;
    n_any_ph = 0; n_mem = 0;
    int_pend = irq; op = o; start_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    if (poke) begin op = 3'd4; start_addr = 32'h0; start = 1'b1; end
    while (!done && cyc < 2000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: no done, actual 0 expected 1");
    end
    st = status;
    int_pend = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 0; op = 0; start_addr = 0; src_data = 0; flags_in = 0; int_pend = 0;
    s_busy = 0; s_final = 0; s_inc = 0; s_abort_at = 99; ask_cnt = 0; data_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1", "phase in reset", 32'(cp_phase), 0);
    check("R1", "done in reset", 32'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "phase after reset", 32'(cp_phase), 0);
    check("R1", "mem strobes after reset", 32'({mem_rd, mem_wr}), 0);
  endtask

  task automatic t_internal;
    logic [2:0] st; int cyc;
    run(3'd0, 0, 0, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R5", "internal status", 32'(st), 0);
    check("R5", "internal cycles", 32'(cyc), 2);
    run(3'd0, 0, 3, 2'b11, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R2", "busy-retried status", 32'(st), 0);
    check("R2", "busy-retried cycles", 32'(cyc), 5);
    check("R2", "busy phases", 32'(n_busy_ph), 3);
    check("R2", "no mem in wait", 32'(n_mem), 0);
  endtask

  task automatic t_irq;
    logic [2:0] st; int cyc;
    run(3'd3, 32'h100, 2, 2'b00, 0, 99, 1'b1, 1'b0, st, cyc);
    check("R3", "irq status", 32'(st), 3);
    check("R3", "intr phases", 32'(n_intr_ph), 1);
    check("R3", "no mem on irq", 32'(n_mem), 0);
    check("R3", "irq cycles", 32'(cyc), 3);
    run(3'd0, 0, 0, 2'b00, 0, 99, 1'b1, 1'b0, st, cyc);
    check("R3", "irq ignored without busy", 32'(st), 0);
  endtask

  task automatic t_cannot;
    logic [2:0] st; int cyc;
    flags_in = 4'b1010;
    run(3'd2, 0, 1, 2'b10, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R4", "cannot status", 32'(st), 1);
    check("R4", "failed read value", rd_data, 32'hA000_0000);
    run(3'd3, 32'h100, 0, 2'b10, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R4", "cannot load status", 32'(st), 1);
    check("R4", "cannot load no mem", 32'(n_mem), 0);
    run(3'd6, 0, 0, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R4", "bad op status", 32'(st), 1);
    check("R4", "bad op cycles", 32'(cyc), 1);
  endtask

  task automatic t_regs;
    logic [2:0] st; int cyc;
    src_data = 32'hDEAD_BEEF;
    run(3'd1, 0, 0, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R6", "put status", 32'(st), 0);
    check("R6", "put data phases", 32'(n_data_ph), 1);
    check("R6", "put word", log_data[0], 32'hDEAD_BEEF);
    run(3'd2, 0, 2, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R7", "get status", 32'(st), 0);
    check("R7", "get value", rd_data, 32'hC0DE_0000);
  endtask

  task automatic t_bursts;
    logic [2:0] st; int cyc;
    run(3'd3, 32'h100, 1, 2'b00, 3, 99, 1'b0, 1'b0, st, cyc);
    check("R8", "load status", 32'(st), 0);
    check("R8", "load words", 32'(n_mem), 4);
    for (int k = 0; k < 4; k++) begin
      check("R8", "load addr", log_addr[k], 32'h100 + 32'(4*k));
      check("R8", "load word", log_data[k], (32'h100 + 32'(4*k)) ^ 32'hA5A5_0000);
    end
    run(3'd4, 32'h200, 0, 2'b11, 2, 99, 1'b0, 1'b0, st, cyc);
    check("R8", "store status", 32'(st), 0);
    check("R8", "store words", 32'(n_mem), 3);
    for (int k = 0; k < 3; k++) begin
      check("R8", "store addr", log_addr[k], 32'h200 + 32'(4*k));
      check("R8", "store word", log_data[k], 32'hC0DE_0000 + 32'(k));
    end
    run(3'd3, 32'h10, 0, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R9", "low-address load allowed", 32'(st), 0);
    check("R8", "single word", 32'(n_mem), 1);
  endtask

  task automatic t_aborts;
    logic [2:0] st; int cyc;
    run(3'd4, 32'h10, 0, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R9", "vector store status", 32'(st), 2);
    check("R9", "vector store no phase", 32'(n_any_ph), 0);
    check("R9", "vector store cycles", 32'(cyc), 1);
    run(3'd3, 32'h0400_0000, 0, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R9", "range load status", 32'(st), 2);
    check("R9", "range load no phase", 32'(n_any_ph), 0);
    run(3'd3, 32'h300, 0, 2'b00, 3, 1, 1'b0, 1'b0, st, cyc);
    check("R10", "mem abort status", 32'(st), 2);
    check("R10", "burst not shortened", 32'(n_mem), 4);
  endtask

  task automatic t_timeout;
    logic [2:0] st; int cyc;
    run(3'd0, 0, 100000, 2'b00, 0, 99, 1'b0, 1'b0, st, cyc);
    check("R11", "timeout status", 32'(st), 4);
    check("R11", "busy phases", 32'(n_busy_ph), 255);
    check("R11", "timeout cycles", 32'(cyc), 257);
  endtask

  task automatic t_restart;
    logic [2:0] st; int cyc;
    run(3'd0, 0, 4, 2'b00, 0, 99, 1'b0, 1'b1, st, cyc);
    check("R12", "second strobe ignored status", 32'(st), 0);
    check("R12", "second strobe ignored cycles", 32'(cyc), 6);
    check("R12", "no store from strobe", 32'(n_mem), 0);
  endtask

  initial begin
    t_reset();
    t_internal();
    t_irq();
    t_cannot();
    t_regs();
    t_bursts();
    t_aborts();
    t_timeout();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule